// File: doc/BRIEF.md
# Shared-Bus Instruction Fetch Sequencer

This block is the timing-and-control part of a small processor core, limited to instruction fetch. A program counter, a memory address register, a memory data register and an instruction register all sit on one internal bus. The sequencer decides in every cycle which single source drives that bus and which register captures it. It runs each fetch as four ordered register transfers:

- the counter value is moved into the address register;
- memory is read into the data register;
- the data register is moved into the instruction register;
- the counter is advanced through an incrementer that also drives the bus.

On the outside, the address register alone drives the outbound address lines. The data register faces the memory data lines: read data comes in, and the register's contents are offered as write data. A read strobe goes out to memory and a ready line comes back. While the run input is high, fetches follow one another back to back. Each completed fetch is marked by a one-cycle done pulse.

Top module: `ifetch_ctrl`

## Requirements
- R1: While reset is active, and in the first cycle after it is released, the program counter, address lines and instruction output read zero. Read and write strobes are low, no bus driver is enabled, and the done pulse is low.
- R2: While run is low and the sequencer is idle, no read is issued and the program counter does not change.
- R3: When the read strobe first rises in a fetch, the address lines already carry the program counter value of that fetch.
- R4: The read strobe stays high until ready is sampled high at a clock edge, so it is high for exactly (wait cycles + 1) cycles. It drops in the cycle after that edge.
- R5: After a fetch, the instruction output equals the memory word at the fetched address.
- R6: The program counter advances by one only after the instruction register has loaded, and wraps from its all-ones value to zero.
- R7: The bus driver enable vector, with bit 0 for the counter, bit 1 for the data register and bit 2 for the incrementer, never has more than one bit set.
- R8: The done pulse lasts one cycle. With run held high, successive pulses are 4 + w cycles apart, where w is the number of cycles ready was held low during that fetch's read.
- R9: The write strobe is never asserted by a fetch.
- R10: If run is dropped during a fetch, that fetch completes with its done pulse and the sequencer then stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Keep fetching while high |
| mem_rdy | input | 1 | Memory ready for the current read |
| mem_rdata | input | DW | Read data from memory |
| mem_addr | output | AW | Address lines, driven from the address register |
| mem_wdata | output | DW | Write data, driven from the data register |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| pc_q | output | AW | Program counter |
| ir_q | output | DW | Instruction register |
| bus_drv | output | 3 | One-hot internal bus driver enables |
| fetch_done | output | 1 | One-cycle pulse when a fetch completes |

## Verification
Each internal register fault appears at the ports within one fetch. A wrong address-register load shows up as a wrong address when the read rises. A wrong data-register or instruction-register load shows up as a wrong instruction at the next done pulse. A missed or doubled increment shows up as a wrong counter at that same pulse. A sequencer that skips or repeats a step changes the spacing between done pulses, or changes how long the read strobe is held, in the very fetch where it goes wrong. A collision on the shared bus is visible in the same cycle on the driver enable vector. The sweep walks the counter across every address, including the wrap, with wait lengths that change from fetch to fetch.

// File: rtl/ifetch_pkg.sv
package ifetch_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ADDR   = 3'd1,
    ST_READ   = 3'd2,
    ST_LOADIR = 3'd3,
    ST_BUMP   = 3'd4
  } fetch_state_e;

  localparam int NSRC    = 3;
  localparam int SRC_PC  = 0;
  localparam int SRC_MDR = 1;
  localparam int SRC_INC = 2;

endpackage

// File: rtl/ifetch_rst_sync.sv
module ifetch_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = shreg[STAGES-1];

endmodule

// File: rtl/ifetch_fsm.sv
module ifetch_fsm
  import ifetch_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            mem_rdy,
  output logic [NSRC-1:0] drv,
  output logic            ld_mar,
  output logic            ld_mdr,
  output logic            ld_ir,
  output logic            ld_pc,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            fetch_done
);

  fetch_state_e state_q, state_d;
  logic         done_q, done_d;

  // next-state and decode
  always_comb begin
    state_d = state_q;
    drv     = '0;
    ld_mar  = 1'b0;
    ld_mdr  = 1'b0;
    ld_ir   = 1'b0;
    ld_pc   = 1'b0;
    mem_rd  = 1'b0;
    mem_wr  = 1'b0;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (run) state_d = ST_ADDR;
      end
      ST_ADDR: begin
        drv[SRC_PC] = 1'b1;
        ld_mar      = 1'b1;
        state_d     = ST_READ;
      end
      ST_READ: begin
        mem_rd = 1'b1;
        if (mem_rdy) begin
          ld_mdr  = 1'b1;
          state_d = ST_LOADIR;
        end
      end
      ST_LOADIR: begin
        drv[SRC_MDR] = 1'b1;
        ld_ir        = 1'b1;
        state_d      = ST_BUMP;
      end
      ST_BUMP: begin
        drv[SRC_INC] = 1'b1;
        ld_pc        = 1'b1;
        done_d       = 1'b1;
        state_d      = run ? ST_ADDR : ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign fetch_done = done_q;

  // R7
  bus_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drv));

  // R4
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_rdy) |=> mem_rd);

  // R4
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && mem_rdy) |=> !mem_rd);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done |=> !fetch_done);

  // R9
  no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> (!mem_rd && drv == '0));

endmodule

// File: rtl/ifetch_regs.sv
module ifetch_regs
  import ifetch_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] drv,
  input  logic            ld_mar,
  input  logic            ld_mdr,
  input  logic            ld_ir,
  input  logic            ld_pc,
  input  logic [DW-1:0]   mem_rdata,
  output logic [AW-1:0]   mar_q,
  output logic [DW-1:0]   mdr_q,
  output logic [DW-1:0]   ir_q,
  output logic [AW-1:0]   pc_q
);

  localparam int BW = (AW > DW) ? AW : DW;

  logic [BW-1:0] src    [NSRC];
  logic [BW-1:0] masked [NSRC];
  logic [BW-1:0] bus;
  logic [AW-1:0] pc_inc;

  assign pc_inc       = pc_q + {{(AW-1){1'b0}}, 1'b1};
  assign src[SRC_PC]  = BW'(pc_q);
  assign src[SRC_MDR] = BW'(mdr_q);
  assign src[SRC_INC] = BW'(pc_inc);

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_gate
      assign masked[g] = src[g] & {BW{drv[g]}};
    end
  endgenerate

  always_comb begin
    bus = '0;
    for (int i = 0; i < NSRC; i++) bus = bus | masked[i];
  end

  // register process with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mar_q <= '0;
      mdr_q <= '0;
      ir_q  <= '0;
      pc_q  <= '0;
    end else begin
      if (ld_mar) mar_q <= bus[AW-1:0];
      if (ld_mdr) mdr_q <= mem_rdata;
      if (ld_ir)  ir_q  <= bus[DW-1:0];
      if (ld_pc)  pc_q  <= bus[AW-1:0];
    end
  end

  // R3
  addr_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_mdr |-> (mar_q == pc_q));

  // R6
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_pc |=> (pc_q == $past(pc_inc)));

  // R6
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_pc |=> $stable(pc_q));

  // R5
  ir_from_mdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ir |=> (ir_q == $past(mdr_q)));

endmodule

// File: rtl/ifetch_ctrl.sv
module ifetch_ctrl
  import ifetch_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            mem_rdy,
  input  logic [DW-1:0]   mem_rdata,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic [AW-1:0]   pc_q,
  output logic [DW-1:0]   ir_q,
  output logic [NSRC-1:0] bus_drv,
  output logic            fetch_done
);

  logic rst_n_int;
  logic ld_mar, ld_mdr, ld_ir, ld_pc;

  ifetch_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  ifetch_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .run        (run),
    .mem_rdy    (mem_rdy),
    .drv        (bus_drv),
    .ld_mar     (ld_mar),
    .ld_mdr     (ld_mdr),
    .ld_ir      (ld_ir),
    .ld_pc      (ld_pc),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .fetch_done (fetch_done)
  );

  ifetch_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .drv       (bus_drv),
    .ld_mar    (ld_mar),
    .ld_mdr    (ld_mdr),
    .ld_ir     (ld_ir),
    .ld_pc     (ld_pc),
    .mem_rdata (mem_rdata),
    .mar_q     (mem_addr),
    .mdr_q     (mem_wdata),
    .ir_q      (ir_q),
    .pc_q      (pc_q)
  );

  // R3
  rd_rise_addr_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(mem_rd) |-> (mem_addr == pc_q));

endmodule

// File: tb/ifetch_ctrl_tb.sv
module ifetch_ctrl_tb;

  localparam int AW = 8;
  localparam int DW = 8;
  localparam int NFETCH = 261;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          run = 1'b0;
  logic          mem_rdy = 1'b0;
  logic [DW-1:0] mem_rdata;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_rd, mem_wr;
  logic [AW-1:0] pc_q;
  logic [DW-1:0] ir_q;
  logic [2:0]    bus_drv;
  logic          fetch_done;

  int nvec = 0;
  int nbad = 0;
  int exp_pc = 0;
  int gap = 0;
  int rdcnt = 0;
  int nd = 0;
  int w;
  bit active = 1'b0;
  bit prev_rd = 1'b0;
  bit prev_done = 1'b0;

  always #5 clk = ~clk;

  function automatic logic [DW-1:0] memword(input int a);
    return DW'(((a * 37 + 11) & 8'hFF) ^ 8'hC3);
  endfunction

  assign mem_rdata = memword(int'(mem_addr));

  ifetch_ctrl #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .mem_rdy(mem_rdy),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .pc_q(pc_q), .ir_q(ir_q),
    .bus_drv(bus_drv), .fetch_done(fetch_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, expv, $time);
    end
  endtask

  // monitor and memory ready model
  always @(negedge clk) begin
    if (active) begin
      w = exp_pc % 4;
      check($countones(bus_drv) <= 1, "R7 bus drivers", int'(bus_drv), 0);
      check(mem_wr == 1'b0, "R9 write strobe", int'(mem_wr), 0);
      if (mem_rd) begin
        if (!prev_rd) check(int'(mem_addr) == exp_pc, "R3 addr at read", int'(mem_addr), exp_pc);
        mem_rdy = (rdcnt == w);
        rdcnt++;
      end else begin
        mem_rdy = 1'b0;
      end
      gap++;
      if (prev_done) check(!fetch_done, "R8 pulse width", int'(fetch_done), 0);
      if (fetch_done) begin
        if (nd > 0) check(gap == 4 + w, "R8 fetch period", gap, 4 + w);
        check(rdcnt == w + 1, "R4 read length", rdcnt, w + 1);
        check(ir_q == memword(exp_pc), "R5 instruction", int'(ir_q), int'(memword(exp_pc)));
        check(int'(pc_q) == (exp_pc + 1) % 256, "R6 pc advance/wrap", int'(pc_q), (exp_pc + 1) % 256);
        check(int'(mem_addr) == exp_pc, "R3 address held", int'(mem_addr), exp_pc);
        gap = 0;
        rdcnt = 0;
        exp_pc = (exp_pc + 1) % 256;
        nd++;
      end
      prev_rd = mem_rd;
      prev_done = fetch_done;
    end
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog actual=%0d expected=%0d", nd, NFETCH);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: during reset
    check(pc_q == '0 && ir_q == '0 && mem_addr == '0, "R1 regs in reset", int'(pc_q), 0);
    check(!mem_rd && !mem_wr && bus_drv == '0 && !fetch_done, "R1 strobes in reset", int'(mem_rd), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pc_q == '0 && ir_q == '0 && mem_addr == '0, "R1 regs after release", int'(ir_q), 0);
    check(!mem_rd && bus_drv == '0 && !fetch_done, "R1 strobes after release", int'(bus_drv), 0);
    // R2: run low keeps the sequencer idle
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check(!mem_rd && pc_q == '0, "R2 idle without run", int'(mem_rd), 0);
    end
    active = 1'b1;
    run = 1'b1;
    wait (nd == NFETCH - 1);
    run = 1'b0;
    wait (nd == NFETCH);
    // R10: current fetch completed, now idle
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check(!mem_rd && !fetch_done, "R10 idle after run drop", int'(mem_rd), 0);
      check(int'(pc_q) == NFETCH % 256, "R10 pc frozen", int'(pc_q), NFETCH % 256);
    end
    check(nd == NFETCH, "R10 fetch count", nd, NFETCH);
    summary();
  end

endmodule